// File: doc/BRIEF.md
# Link Bootstrap Loader Controller

This block sequences the boot of a small processor node straight after reset. Several link receivers feed it byte streams that are already deserialised. Each stream has a valid/ready handshake. On the other side the block drives a word-wide memory port with byte enables, one reply byte stream for each link, and a start address with a one-cycle start pulse for the core.

A mode input is sampled while reset is held. When that input is high, the block never accepts a link byte. It starts the core at the byte address two below the top of the address space.

When the mode input is low, the block waits for a length byte on any link and then locks onto the link that sent it. A length of two or more loads that many code bytes into low memory and then starts the core there. It also reports which link the code came from. A length of 0 writes one word to memory (a poke). A length of 1 reads one word and sends it back (a peek). After either of these the block waits for another length byte, and the core stays unbooted.

Top module: `link_boot_ctrl`

## Requirements
- R1: If `boot_rom` is high during reset, then after reset `start` pulses once with `start_addr` = 2^ADDR_W - 2 and `boot_link` = 0. No `rx_ready` bit ever rises and no memory access is issued.
- R2: If `boot_rom` is low during reset, the first byte accepted on any link is a length byte. When several links are valid in the same cycle, the lowest link index is accepted.
- R3: For a length N >= 2, the next N bytes from the locked link are stored at consecutive byte addresses, starting at LOAD_BASE. Byte address b maps to `mem_addr` = b / (WORD_W/8) and to the single `mem_be` bit b mod (WORD_W/8). The byte is placed in that lane of `mem_wdata`.
- R4: One cycle after the write of the last load byte, `start` pulses for one cycle with `start_addr` = LOAD_BASE and `boot_link` = the locked link's index. After that, `rx_ready` stays low until reset.
- R5: Length 0 (poke) is followed by a word address and then a data word, each sent as WORD_W/8 bytes, least significant byte first. It causes exactly one write of that word to that word address, with every `mem_be` bit set.
- R6: Length 1 (peek) is followed by a word address sent least significant byte first. It issues one read and no write. The word is then sent on the `tx` stream of the same link, least significant byte first.
- R7: After a peek or a poke completes, the block accepts a new length byte, and `start` is not asserted.
- R8: Once a length byte is accepted, `rx_ready` stays low for all other links until the request or load finishes.
- R9: At most one bit of `rx_ready` is high in any cycle. `start` is never high for two consecutive cycles.
- R10: Read data on `mem_rdata` is expected one cycle after `mem_re` is high (a registered, block-RAM style read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_rom | input | 1 | Boot mode, sampled during reset: 1 = start from the top of memory |
| rx_valid | input | N_LINKS | Byte valid, one bit per link |
| rx_data | input | 8*N_LINKS | Byte from each link, link i in bits [8i+7:8i] |
| rx_ready | output | N_LINKS | Byte accepted, one bit per link |
| tx_valid | output | N_LINKS | Reply byte valid, one bit per link |
| tx_data | output | 8 | Reply byte, shared by all links |
| tx_ready | input | N_LINKS | Reply byte taken, one bit per link |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W - log2(WORD_W/8) | Word address |
| mem_wdata | output | WORD_W | Write data |
| mem_be | output | WORD_W/8 | Byte-lane write enables |
| mem_rdata | input | WORD_W | Read data, valid one cycle after `mem_re` |
| start | output | 1 | One-cycle core start pulse |
| start_addr | output | ADDR_W | Byte address at which the core starts |
| boot_link | output | log2(N_LINKS) | Link that delivered the code image |

## Verification
The bench covers three cases. It holds a length byte on link 3 while link 0 starts a peek in the same cycle: a design with the wrong arbitration order or a leaky lock would accept link 3 early, and its load would land in the middle of the peek. It runs a load of length 2, the shortest legal one. An off-by-one end count there would either start too soon or swallow a following byte. It checks that poke data is visible to a later peek, and that load bytes can be read back as words after a fresh reset. A swapped byte order or a wrong lane select would then show up as a wrong reply byte. It also keeps links offering bytes in ROM mode and after the start pulse, where any accepted byte is an error.

// File: rtl/boot_pkg.sv
`timescale 1ns/1ps
package boot_pkg;
  typedef enum logic [3:0] {
    ST_INIT, ST_LEN, ST_ADDR, ST_DATA, ST_RD, ST_RWAIT, ST_TX, ST_LOAD, ST_GO, ST_DONE
  } boot_state_e;

  localparam logic [7:0] LEN_POKE = 8'd0;
  localparam logic [7:0] LEN_PEEK = 8'd1;
endpackage

// File: rtl/boot_link_mux.sv
`timescale 1ns/1ps
module boot_link_mux #(
  parameter int N_LINKS = 4,
  localparam int LINK_W = $clog2(N_LINKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_LINKS-1:0]   rx_valid,
  input  logic [8*N_LINKS-1:0] rx_data,
  output logic [N_LINKS-1:0]   rx_ready,
  input  logic                 arb_en,
  input  logic                 hold_en,
  output logic                 cur_valid,
  output logic [7:0]           cur_data,
  output logic [LINK_W-1:0]    link_sel,
  input  logic                 tx_en,
  input  logic [7:0]           tx_byte,
  input  logic [N_LINKS-1:0]   tx_ready,
  output logic [N_LINKS-1:0]   tx_valid,
  output logic [7:0]           tx_data,
  output logic                 tx_ack
);
  logic [LINK_W-1:0] pick;
  logic [LINK_W-1:0] eff;
  logic              any_valid;
  logic [LINK_W-1:0] sel_q;

  // lowest index wins (R2)
  always_comb begin
    pick = '0;
    for (int i = N_LINKS - 1; i >= 0; i--) begin
      if (rx_valid[i]) pick = LINK_W'(i);
    end
  end

  assign any_valid = |rx_valid;
  assign eff       = arb_en ? pick : sel_q;
  assign rx_ready  = ((arb_en && any_valid) || hold_en) ? (N_LINKS'(1) << eff) : '0;
  assign cur_valid = (arb_en || hold_en) && rx_valid[eff];
  assign cur_data  = rx_data[int'(eff)*8 +: 8];

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (arb_en && any_valid) sel_q <= pick;
  end

  assign link_sel = sel_q;
  assign tx_valid = tx_en ? (N_LINKS'(1) << sel_q) : '0;
  assign tx_data  = tx_byte;
  assign tx_ack   = tx_en && tx_ready[sel_q];

  p_one_ready_r9: assert property (@(posedge clk) disable iff (rst) $onehot0(rx_ready))
    else $error("rx_ready has more than one bit set");
  p_tx_onehot_r6: assert property (@(posedge clk) disable iff (rst) $onehot0(tx_valid))
    else $error("tx_valid on more than one link");
endmodule

// File: rtl/boot_seq.sv
`timescale 1ns/1ps
module boot_seq
  import boot_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 12,
  parameter int LOAD_BASE = 64,
  parameter int LINK_W    = 2,
  localparam int BPW      = WORD_W / 8,
  localparam int LB       = $clog2(BPW),
  localparam int WADDR_W  = ADDR_W - LB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               boot_rom,
  input  logic               cur_valid,
  input  logic [7:0]         cur_data,
  input  logic [LINK_W-1:0]  link_sel,
  output logic               arb_en,
  output logic               hold_en,
  output logic               tx_en,
  output logic [7:0]         tx_byte,
  input  logic               tx_ack,
  output logic               mem_we,
  output logic               mem_re,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  output logic [BPW-1:0]     mem_be,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               start,
  output logic [ADDR_W-1:0]  start_addr,
  output logic [LINK_W-1:0]  boot_link
);
  boot_state_e       state;
  logic              rom_q;
  logic              is_peek;
  logic [7:0]        len_q;
  logic [7:0]        cnt_q;
  logic [WORD_W-1:0] wbuf;
  logic [WORD_W-1:0] nxt;
  logic [WADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] ld_addr;
  logic              last_w;

  assign nxt     = {cur_data, wbuf[WORD_W-1:8]};
  assign last_w  = (cnt_q == 8'(BPW - 1));
  assign ld_addr = ADDR_W'(LOAD_BASE) + ADDR_W'(cnt_q);
  assign tx_byte = wbuf[7:0];
  assign arb_en  = (state == ST_LEN);
  assign hold_en = (state == ST_ADDR) || (state == ST_DATA) || (state == ST_LOAD);
  assign tx_en   = (state == ST_TX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_INIT;
      rom_q      <= boot_rom;
      is_peek    <= 1'b0;
      len_q      <= '0;
      cnt_q      <= '0;
      wbuf       <= '0;
      addr_q     <= '0;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_be     <= '0;
      start      <= 1'b0;
      start_addr <= '0;
      boot_link  <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      start  <= 1'b0;
      case (state)
        ST_INIT: begin
          if (rom_q) begin
            start      <= 1'b1;
            start_addr <= {{(ADDR_W-1){1'b1}}, 1'b0};
            state      <= ST_DONE;
          end else begin
            state <= ST_LEN;
          end
        end
        ST_LEN: begin
          if (cur_valid) begin
            len_q   <= cur_data;
            cnt_q   <= '0;
            is_peek <= (cur_data == LEN_PEEK);
            if (cur_data == LEN_POKE || cur_data == LEN_PEEK) state <= ST_ADDR;
            else state <= ST_LOAD;
          end
        end
        ST_ADDR: begin
          if (cur_valid) begin
            wbuf  <= nxt;
            cnt_q <= cnt_q + 8'd1;
            if (last_w) begin
              cnt_q  <= '0;
              addr_q <= nxt[WADDR_W-1:0];
              if (is_peek) begin
                mem_re   <= 1'b1;
                mem_addr <= nxt[WADDR_W-1:0];
                state    <= ST_RD;
              end else begin
                state <= ST_DATA;
              end
            end
          end
        end
        ST_DATA: begin
          if (cur_valid) begin
            wbuf  <= nxt;
            cnt_q <= cnt_q + 8'd1;
            if (last_w) begin
              cnt_q     <= '0;
              mem_we    <= 1'b1;
              mem_addr  <= addr_q;
              mem_wdata <= nxt;
              mem_be    <= '1;
              state     <= ST_LEN;
            end
          end
        end
        ST_RD: state <= ST_RWAIT;
        ST_RWAIT: begin
          wbuf  <= mem_rdata;
          cnt_q <= '0;
          state <= ST_TX;
        end
        ST_TX: begin
          if (tx_ack) begin
            wbuf  <= wbuf >> 8;
            cnt_q <= cnt_q + 8'd1;
            if (last_w) begin
              cnt_q <= '0;
              state <= ST_LEN;
            end
          end
        end
        ST_LOAD: begin
          if (cur_valid) begin
            mem_we    <= 1'b1;
            mem_addr  <= ld_addr[ADDR_W-1:LB];
            mem_be    <= BPW'(1) << ld_addr[LB-1:0];
            mem_wdata <= {BPW{cur_data}};
            cnt_q     <= cnt_q + 8'd1;
            if (cnt_q == len_q - 8'd1) state <= ST_GO;
          end
        end
        ST_GO: begin
          start      <= 1'b1;
          start_addr <= ADDR_W'(LOAD_BASE);
          boot_link  <= link_sel;
          state      <= ST_DONE;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  p_rom_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    rom_q |-> (!mem_we && !mem_re && !arb_en && !hold_en))
    else $error("ROM boot touched links or memory");
  p_load_lane_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(state) == ST_LOAD) |-> $onehot(mem_be))
    else $error("load write without a single byte lane");
  p_done_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |-> (!arb_en && !hold_en && !tx_en && !mem_we))
    else $error("activity after start");
  p_poke_full_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(state) == ST_DATA) |-> (mem_be == {BPW{1'b1}}))
    else $error("poke write without all lanes");
  p_peek_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> !mem_we)
    else $error("peek wrote memory");
  p_start_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> !start)
    else $error("start longer than one cycle");
  p_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (state == ST_RWAIT))
    else $error("read data not captured one cycle after read");
endmodule

// File: rtl/link_boot_ctrl.sv
`timescale 1ns/1ps
module link_boot_ctrl #(
  parameter int N_LINKS   = 4,
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 12,
  parameter int LOAD_BASE = 64,
  localparam int LINK_W   = $clog2(N_LINKS),
  localparam int BPW      = WORD_W / 8,
  localparam int WADDR_W  = ADDR_W - $clog2(BPW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 boot_rom,
  input  logic [N_LINKS-1:0]   rx_valid,
  input  logic [8*N_LINKS-1:0] rx_data,
  output logic [N_LINKS-1:0]   rx_ready,
  output logic [N_LINKS-1:0]   tx_valid,
  output logic [7:0]           tx_data,
  input  logic [N_LINKS-1:0]   tx_ready,
  output logic                 mem_we,
  output logic                 mem_re,
  output logic [WADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  output logic [BPW-1:0]       mem_be,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 start,
  output logic [ADDR_W-1:0]    start_addr,
  output logic [LINK_W-1:0]    boot_link
);
  logic              arb_en, hold_en, tx_en, tx_ack, cur_valid;
  logic [7:0]        cur_data, tx_byte;
  logic [LINK_W-1:0] link_sel;

  boot_link_mux #(.N_LINKS(N_LINKS)) u_mux (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .arb_en(arb_en), .hold_en(hold_en),
    .cur_valid(cur_valid), .cur_data(cur_data), .link_sel(link_sel),
    .tx_en(tx_en), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ack(tx_ack)
  );

  boot_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LOAD_BASE(LOAD_BASE), .LINK_W(LINK_W)) u_seq (
    .clk(clk), .rst(rst), .boot_rom(boot_rom),
    .cur_valid(cur_valid), .cur_data(cur_data), .link_sel(link_sel),
    .arb_en(arb_en), .hold_en(hold_en), .tx_en(tx_en), .tx_byte(tx_byte), .tx_ack(tx_ack),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata),
    .start(start), .start_addr(start_addr), .boot_link(boot_link)
  );

  p_lock_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (hold_en && $past(hold_en)) |-> $stable(link_sel))
    else $error("link lock moved during a request");
  p_ready_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (hold_en && rx_ready != '0) |-> rx_ready[link_sel])
    else $error("ready given to an unlocked link");
  p_tx_same_link_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_valid != '0) |-> tx_valid[link_sel])
    else $error("reply on a different link");
endmodule

// File: tb/test_link_boot_ctrl.sv
`timescale 1ns/1ps
module test_link_boot_ctrl;
  localparam int NL = 4, WW = 16, AW = 12, LBASE = 64;
  localparam int BPW = WW / 8, WAW = AW - 1;

  logic clk = 1'b0, rst = 1'b1, boot_rom = 1'b0;
  logic [NL-1:0] rx_valid = '0, tx_ready = '0;
  logic [8*NL-1:0] rx_data = '0;
  logic [NL-1:0] rx_ready, tx_valid;
  logic [7:0] tx_data;
  logic mem_we, mem_re, start;
  logic [WAW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata, mem_rdata;
  logic [BPW-1:0] mem_be;
  logic [AW-1:0] start_addr;
  logic [1:0] boot_link;

  int checks = 0, failures = 0;
  logic [NL-1:0] forbid = '0;
  logic tx_phase = 1'b0;
  logic [WW-1:0] mem [2**WAW];

  int exp_w_addr[$], exp_w_be[$], exp_w_data[$];
  int exp_t_link[$], exp_t_byte[$];
  int exp_s_addr[$], exp_s_link[$];

  always #2.5 clk = ~clk;

  link_boot_ctrl #(.N_LINKS(NL), .WORD_W(WW), .ADDR_W(AW), .LOAD_BASE(LBASE)) i_link_boot_ctrl (
    .clk(clk), .rst(rst), .boot_rom(boot_rom),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata),
    .start(start), .start_addr(start_addr), .boot_link(boot_link)
  );

  function automatic logic [WW-1:0] init_word(int a);
    return WW'(a * 37 + 5);
  endfunction

  // memory model: registered read
  initial begin
    for (int i = 0; i < 2**WAW; i++) mem[i] = init_word(i);
  end
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (mem_we)
      for (int l = 0; l < BPW; l++)
        if (mem_be[l]) mem[mem_addr][l*8 +: 8] <= mem_wdata[l*8 +: 8];
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // per-cycle reference comparison
  always @(negedge clk) begin
    tx_phase = ~tx_phase;
    tx_ready = {NL{tx_phase}};
    #2;
    if (!rst) begin
      chk($onehot0(rx_ready), "R9 ready onehot", int'(rx_ready), 0);
      chk((rx_ready & forbid) == '0, "R1/R4/R8 forbidden ready", int'(rx_ready), 0);
      if (mem_we) begin
        if (exp_w_addr.size() == 0) chk(0, "R3/R5/R6 unexpected write", int'(mem_addr), -1);
        else begin
          automatic int ea = exp_w_addr.pop_front();
          automatic int eb = exp_w_be.pop_front();
          automatic int ed = exp_w_data.pop_front();
          automatic logic [WW-1:0] m = '0;
          for (int l = 0; l < BPW; l++) if (mem_be[l]) m[l*8 +: 8] = 8'hFF;
          chk(int'(mem_addr) == ea, "R3/R5 write addr", int'(mem_addr), ea);
          chk(int'(mem_be) == eb, "R3/R5 write lanes", int'(mem_be), eb);
          chk(int'(mem_wdata & m) == ed, "R3/R5 write data", int'(mem_wdata & m), ed);
        end
      end
      for (int l = 0; l < NL; l++) begin
        if (tx_valid[l] && tx_ready[l]) begin
          if (exp_t_link.size() == 0) chk(0, "R6 unexpected reply", l, -1);
          else begin
            automatic int el = exp_t_link.pop_front();
            automatic int eb2 = exp_t_byte.pop_front();
            chk(l == el, "R6 reply link", l, el);
            chk(int'(tx_data) == eb2, "R6 reply byte", int'(tx_data), eb2);
          end
        end
      end
      if (start) begin
        if (exp_s_addr.size() == 0) chk(0, "R7/R9 unexpected start", int'(start_addr), -1);
        else begin
          automatic int sa = exp_s_addr.pop_front();
          automatic int sl = exp_s_link.pop_front();
          chk(int'(start_addr) == sa, "R1/R4 start addr", int'(start_addr), sa);
          chk(int'(boot_link) == sl, "R4 boot link", int'(boot_link), sl);
        end
      end
    end
  end

  task automatic send(input int l, input logic [7:0] b[$]);
    foreach (b[k]) begin
      @(negedge clk);
      rx_valid[l] = 1'b1;
      rx_data[l*8 +: 8] = b[k];
      #1;
      while (!rx_ready[l]) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    rx_valid[l] = 1'b0;
  endtask

  task automatic do_reset(input logic rom);
    @(negedge clk);
    rst = 1'b1;
    boot_rom = rom;
    rx_valid = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      if (exp_w_addr.size() == 0 && exp_t_link.size() == 0 && exp_s_addr.size() == 0) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(exp_w_addr.size() == 0, "R3/R5 writes done", exp_w_addr.size(), 0);
    chk(exp_t_link.size() == 0, "R6 replies done", exp_t_link.size(), 0);
    chk(exp_s_addr.size() == 0, "R1/R4 start seen", exp_s_addr.size(), 0);
  endtask

  task automatic exp_reply(input int l, input logic [WW-1:0] w);
    for (int k = 0; k < BPW; k++) begin
      exp_t_link.push_back(l);
      exp_t_byte.push_back(int'(w[k*8 +: 8]));
    end
  endtask

  task automatic exp_load(input logic [7:0] b[$]);
    foreach (b[k]) begin
      automatic int ba = LBASE + k;
      exp_w_addr.push_back(ba / BPW);
      exp_w_be.push_back(1 << (ba % BPW));
      exp_w_data.push_back(int'(b[k]) << (8 * (ba % BPW)));
    end
  endtask

  initial begin
    // R1: ROM boot; link 0 keeps offering a byte
    forbid = '1;
    exp_s_addr.push_back(2**AW - 2);
    exp_s_link.push_back(0);
    do_reset(1'b1);
    chk(rx_ready == '0 && start == 1'b0, "R1 reset state", int'(rx_ready), 0);
    rx_valid[0] = 1'b1;
    rx_data[7:0] = 8'h07;
    repeat (20) @(negedge clk);
    rx_valid[0] = 1'b0;
    drain();

    // R2/R5: poke on link 2, word 0x123 <= 0xBEEF
    forbid = '0;
    do_reset(1'b0);
    exp_w_addr.push_back(12'h123); exp_w_be.push_back(3); exp_w_data.push_back(16'hBEEF);
    send(2, '{8'h00, 8'h23, 8'h01, 8'hEF, 8'hBE});
    drain();

    // R6/R7: peek back the poked word on link 1, then an untouched word on link 2
    exp_reply(1, 16'hBEEF);
    send(1, '{8'h01, 8'h23, 8'h01});
    drain();
    exp_reply(2, init_word(16));
    send(2, '{8'h01, 8'h10, 8'h00});
    drain();

    // R2/R8: link 0 and link 3 both offer a length; link 0 (peek) wins, link 3 then loads
    exp_reply(0, init_word(16'h55));
    exp_load('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55});
    exp_s_addr.push_back(LBASE);
    exp_s_link.push_back(3);
    forbid = 4'b1000;
    fork
      begin send(0, '{8'h01, 8'h55, 8'h00}); forbid = '0; end
      send(3, '{8'h05, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55});
    join
    drain();

    // R4: nothing accepted after start
    forbid = '1;
    rx_valid[1] = 1'b1;
    rx_data[15:8] = 8'h01;
    repeat (20) @(negedge clk);
    rx_valid[1] = 1'b0;
    chk(exp_w_addr.size() == 0 && exp_t_link.size() == 0, "R4 quiet after start", 0, 0);

    // R3: loaded bytes read back as words after a new reset; shortest load (length 2)
    forbid = '0;
    do_reset(1'b0);
    exp_reply(0, 16'h4433);
    send(0, '{8'h01, 8'h21, 8'h00});
    drain();
    exp_reply(2, 16'h2211);
    send(2, '{8'h01, 8'h20, 8'h00});
    drain();
    exp_load('{8'hAA, 8'h5C});
    exp_s_addr.push_back(LBASE);
    exp_s_link.push_back(1);
    send(1, '{8'h02, 8'hAA, 8'h5C});
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule